// File: doc/BRIEF.md
# Pipelined Address Bus Cycle Controller

This block sequences bus cycles for a 32-bit processor bus interface. Internal requests carry an address and a cycle type through a valid/ready handshake. The controller puts each accepted request on the bus with a one-clock address strobe. It then holds the cycle until the external ready input ends it. One clock stands for one bus state.

The controller can issue the next address early. During a wait state of the running cycle, the system may assert the next-address input. If a request is waiting, the controller then drives the next address and strobe from the following clock, before the current cycle is acknowledged. This choice is made anew in every cycle. A cycle that starts from idle, or that follows a zero-wait acknowledge, is always issued non-pipelined. A 16-bit bus-size indication seen in the same wait state overrides the early-issue request. A flag output tells, at each strobe, which of the two ways the address was issued.

Top module: `pipe_bus_ctrl`

## Requirements
- R1: After reset, state_o is 0 (idle), ads_o is 0 and pipe_o is 0. The state encoding is idle=0, T1=1, T2=2, T1P=3, T2P=4.
- R2: In idle, req_ready_o is 1. An accepted request appears on addr_o/type_o in the next clock, with ads_o high for exactly that one clock, pipe_o 0 and state T1.
- R3: T1 and T1P are always followed by T2. In T1, T1P and T2P, req_ready_o is 0.
- R4: In T2 with rdy_i high, the cycle ends. A pending request is then accepted and issued non-pipelined (state T1, pipe_o 0), whatever next_addr_i is. With no pending request, the state becomes idle.
- R5: In T2 with rdy_i low, next_addr_i high, bus16_i low and a request pending, the request is accepted. The next state is T2P, with ads_o high for one clock and pipe_o 1.
- R6: next_addr_i is sampled only in a T2 clock with rdy_i low. Its value in T1, T1P, T2P, or in a T2 ended by ready, has no effect.
- R7: Once next_addr_i has been sampled high in a cycle, a request that arrives in a later wait state of the same cycle is issued pipelined, even with next_addr_i low by then.
- R8: bus16_i sampled high in a T2 wait state blocks pipelining for the rest of that cycle. This holds even when next_addr_i is high in the same clock. The next request is then issued non-pipelined after ready.
- R9: T2P holds until rdy_i is high, then moves to T1P. addr_o and type_o stay unchanged until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one bus state per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Internal request pending |
| req_addr_i | input | ADDR_W | Request address |
| req_type_i | input | TYPE_W | Request cycle definition |
| req_ready_o | output | 1 | Request accepted this clock when valid |
| next_addr_i | input | 1 | External next-address request |
| bus16_i | input | 1 | External 16-bit bus-size indication |
| rdy_i | input | 1 | Current cycle acknowledge |
| ads_o | output | 1 | Address strobe, one clock per issue |
| addr_o | output | ADDR_W | Bus address |
| type_o | output | TYPE_W | Bus cycle definition |
| pipe_o | output | 1 | Last issue was pipelined |
| state_o | output | 3 | Bus state code |

## Verification
The bench builds the controller with a 16-bit address and a 3-bit cycle type. These narrow widths change no timing, so every address and type seen at a strobe can be told apart by eye in a failure line. Each scenario walks the state sequence one clock at a time. The scenarios cover back-to-back zero-wait cycles, entry into and continuation of pipelined issue, the bus-size override, a request that arrives late after an early next-address sample, and next-address asserted outside its sampling window.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  localparam int STATE_W = 3;
  typedef enum logic [STATE_W-1:0] {
    ST_TI  = 3'd0,
    ST_T1  = 3'd1,
    ST_T2  = 3'd2,
    ST_T1P = 3'd3,
    ST_T2P = 3'd4
  } bus_state_e;
endpackage

// File: rtl/pbc_window.sv
// Per-cycle sampling of next-address and bus-size in T2 wait states.
module pbc_window (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic sample_i,
  input  logic na_i,
  input  logic b16_i,
  output logic pipe_ok_o
);
  logic na_seen_q, blk_q;

  assign pipe_ok_o = sample_i & (na_seen_q | na_i) & ~(blk_q | b16_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      na_seen_q <= 1'b0;
      blk_q     <= 1'b0;
    end else if (clear_i) begin
      na_seen_q <= 1'b0;
      blk_q     <= 1'b0;
    end else if (sample_i) begin
      na_seen_q <= na_seen_q | (na_i & ~b16_i & ~blk_q);
      blk_q     <= blk_q | b16_i;
    end
  end
endmodule

// File: rtl/pbc_fsm.sv
module pbc_fsm
  import pbc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic       rdy_i,
  input  logic       pipe_ok_i,
  output bus_state_e state_o,
  output logic       ready_o,
  output logic       accept_o,
  output logic       pipe_issue_o,
  output logic       sample_o,
  output logic       clear_o
);
  bus_state_e state_q, state_d;

  assign state_o  = state_q;
  assign sample_o = (state_q == ST_T2) & ~rdy_i;
  assign clear_o  = (state_q == ST_T1) | (state_q == ST_T1P);

  always_comb begin
    ready_o = 1'b0;
    case (state_q)
      ST_TI:   ready_o = 1'b1;
      ST_T2:   ready_o = rdy_i | pipe_ok_i;
      default: ready_o = 1'b0;
    endcase
  end

  assign accept_o     = ready_o & req_valid_i;
  assign pipe_issue_o = accept_o & (state_q == ST_T2) & ~rdy_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_TI:   if (accept_o) state_d = ST_T1;
      ST_T1:   state_d = ST_T2;
      ST_T1P:  state_d = ST_T2;
      ST_T2: begin
        if (rdy_i)          state_d = accept_o ? ST_T1 : ST_TI;
        else if (accept_o)  state_d = ST_T2P;
      end
      ST_T2P:  if (rdy_i) state_d = ST_T1P;
      default: state_d = ST_TI;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_TI;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/pbc_issue_reg.sv
// Bus address/definition register, strobe and issue-mode flag.
module pbc_issue_reg #(
  parameter int ADDR_W = 32,
  parameter int TYPE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              pipe_issue_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TYPE_W-1:0] type_i,
  output logic              ads_o,
  output logic              pipe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [TYPE_W-1:0] type_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ads_o  <= 1'b0;
      pipe_o <= 1'b0;
      addr_o <= '0;
      type_o <= '0;
    end else begin
      ads_o <= accept_i;
      if (accept_i) begin
        pipe_o <= pipe_issue_i;
        addr_o <= addr_i;
        type_o <= type_i;
      end
    end
  end
endmodule

// File: rtl/pipe_bus_ctrl.sv
module pipe_bus_ctrl
  import pbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TYPE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [TYPE_W-1:0] req_type_i,
  output logic              req_ready_o,
  input  logic              next_addr_i,
  input  logic              bus16_i,
  input  logic              rdy_i,
  output logic              ads_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [TYPE_W-1:0] type_o,
  output logic              pipe_o,
  output logic [STATE_W-1:0] state_o
);
  bus_state_e st;
  logic accept, pipe_issue, sample, clear, pipe_ok;

  pbc_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .rdy_i        (rdy_i),
    .pipe_ok_i    (pipe_ok),
    .state_o      (st),
    .ready_o      (req_ready_o),
    .accept_o     (accept),
    .pipe_issue_o (pipe_issue),
    .sample_o     (sample),
    .clear_o      (clear)
  );

  pbc_window u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear),
    .sample_i  (sample),
    .na_i      (next_addr_i),
    .b16_i     (bus16_i),
    .pipe_ok_o (pipe_ok)
  );

  pbc_issue_reg #(.ADDR_W(ADDR_W), .TYPE_W(TYPE_W)) u_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .pipe_issue_i (pipe_issue),
    .addr_i       (req_addr_i),
    .type_i       (req_type_i),
    .ads_o        (ads_o),
    .pipe_o       (pipe_o),
    .addr_o       (addr_o),
    .type_o       (type_o)
  );

  assign state_o = st;
endmodule

// File: rtl/pipe_bus_ctrl_chk.sv
module pipe_bus_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rdy_i,
  input logic              ads_o,
  input logic              pipe_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [2:0]        state_o
);
  a_r2_ads_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ads_o |=> !ads_o);
  a_r2_plain_issue_in_t1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ads_o && !pipe_o) |-> (state_o == 3'd1));
  a_r5_pipe_issue_in_t2p: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ads_o && pipe_o) |-> (state_o == 3'd4));
  a_r3_t1_to_t2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1 || state_o == 3'd3) |=> (state_o == 3'd2));
  a_r3_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1 || state_o == 3'd3 || state_o == 3'd4) |-> !req_ready_o);
  a_r4_end_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 && rdy_i && !req_valid_i) |=> (state_o == 3'd0));
  a_r9_t2p_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && rdy_i) |=> (state_o == 3'd3));
  a_r9_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> $stable(addr_o));
endmodule

bind pipe_bus_ctrl pipe_bus_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rdy_i       (rdy_i),
  .ads_o       (ads_o),
  .pipe_o      (pipe_o),
  .addr_o      (addr_o),
  .state_o     (state_o)
);

// File: tb/pipe_bus_ctrl_test.sv
`timescale 1ns/1ps
module pipe_bus_ctrl_test;
  localparam int AW = 16;
  localparam int TW = 3;

  logic clk = 0, rst_n = 0;
  logic vld = 0, na = 0, b16 = 0, rdy = 0;
  logic [AW-1:0] a_in = '0;
  logic [TW-1:0] t_in = '0;
  logic rdy_o, ads, pipe;
  logic [AW-1:0] addr;
  logic [TW-1:0] typ;
  logic [2:0] st;

  int total = 0, bad = 0;
  bit done = 0;
  logic [AW+TW:0] exp_q[$];

  always #5 clk = ~clk;

  pipe_bus_ctrl #(.ADDR_W(AW), .TYPE_W(TW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_addr_i(a_in),
    .req_type_i(t_in), .req_ready_o(rdy_o), .next_addr_i(na), .bus16_i(b16),
    .rdy_i(rdy), .ads_o(ads), .addr_o(addr), .type_o(typ), .pipe_o(pipe),
    .state_o(st)
  );

  task automatic ck(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [TW-1:0] t, input logic p);
    exp_q.push_back({p, t, a});
  endtask

  task automatic drv(input logic v, input logic [AW-1:0] a, input logic [TW-1:0] t,
                     input logic n, input logic b, input logic r);
    vld = v; a_in = a; t_in = t; na = n; b16 = b; rdy = r;
    #1;
  endtask

  task automatic step(input logic v, input logic [AW-1:0] a, input logic [TW-1:0] t,
                      input logic n, input logic b, input logic r, input int exp_st,
                      input string tag);
    drv(v, a, t, n, b, r);
    @(negedge clk);
    ck(st, exp_st, tag);
  endtask

  // monitor: every strobe must match the next expected issue
  always @(negedge clk) begin
    if (rst_n && ads) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R2 unexpected strobe actual=%0h expected=none", addr);
      end else begin
        logic [AW+TW:0] e;
        e = exp_q.pop_front();
        ck({pipe, typ, addr}, e, "R2/R5 issue {pipe,type,addr}");
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    ck(st, 0, "R1 reset state");
    ck(ads, 0, "R1 reset ads");
    ck(pipe, 0, "R1 reset pipe");
    rst_n = 1;
    drv(0, 0, 0, 0, 0, 0);
    ck(rdy_o, 1, "R2 ready in idle");

    // A: zero-wait back-to-back, next_addr ignored with ready
    push(16'h1000, 1, 0);
    step(1, 16'h1000, 1, 1, 0, 0, 1, "R2 idle to T1");
    drv(1, 16'h1004, 2, 1, 0, 0);
    ck(rdy_o, 0, "R3 no accept in T1");
    step(1, 16'h1004, 2, 1, 0, 0, 2, "R3 T1 to T2");
    push(16'h1004, 2, 0);
    step(1, 16'h1004, 2, 1, 0, 1, 1, "R4 back-to-back T1");
    step(0, 0, 0, 0, 0, 0, 2, "R3 T1 to T2");
    step(0, 0, 0, 0, 0, 1, 0, "R4 end to idle");

    // B: enter pipelined issue and stay pipelined
    push(16'h2000, 3, 0);
    step(1, 16'h2000, 3, 0, 0, 0, 1, "R2 idle to T1");
    step(0, 0, 0, 0, 0, 0, 2, "R3 T1 to T2");
    push(16'h2010, 4, 1);
    step(1, 16'h2010, 4, 1, 0, 0, 4, "R5 pipelined to T2P");
    drv(1, 16'h2020, 5, 1, 0, 0);
    ck(rdy_o, 0, "R3 no accept in T2P");
    step(1, 16'h2020, 5, 1, 0, 0, 4, "R9 T2P holds");
    ck(ads, 0, "R9 strobe one clock");
    ck(addr, 16'h2010, "R9 addr held");
    step(1, 16'h2020, 5, 1, 0, 1, 3, "R9 T2P to T1P");
    drv(1, 16'h2020, 5, 1, 0, 0);
    ck(rdy_o, 0, "R3 no accept in T1P");
    step(1, 16'h2020, 5, 1, 0, 0, 2, "R6 T1P to T2 na ignored");
    push(16'h2020, 5, 1);
    step(1, 16'h2020, 5, 1, 0, 0, 4, "R5 pipelined again");
    step(0, 0, 0, 0, 0, 1, 3, "R9 T2P to T1P");
    step(0, 0, 0, 0, 0, 0, 2, "R3 T1P to T2");
    step(0, 0, 0, 0, 0, 1, 0, "R4 end to idle");

    // C: bus size overrides next address
    push(16'h3000, 6, 0);
    step(1, 16'h3000, 6, 0, 0, 0, 1, "R2 idle to T1");
    step(0, 0, 0, 0, 0, 0, 2, "R3 T1 to T2");
    step(1, 16'h3004, 7, 1, 1, 0, 2, "R8 bus16 blocks");
    step(1, 16'h3004, 7, 1, 0, 0, 2, "R8 block persists");
    push(16'h3004, 7, 0);
    step(1, 16'h3004, 7, 1, 0, 1, 1, "R8 plain issue after ready");
    step(0, 0, 0, 0, 0, 0, 2, "R3 T1 to T2");
    step(0, 0, 0, 0, 0, 1, 0, "R4 end to idle");

    // D: next address seen before the request arrives
    push(16'h4000, 1, 0);
    step(1, 16'h4000, 1, 0, 0, 0, 1, "R2 idle to T1");
    step(0, 0, 0, 0, 0, 0, 2, "R3 T1 to T2");
    step(0, 0, 0, 1, 0, 0, 2, "R7 na with no request");
    push(16'h4008, 2, 1);
    step(1, 16'h4008, 2, 0, 0, 0, 4, "R7 late request pipelined");
    step(0, 0, 0, 1, 0, 1, 3, "R9 T2P to T1P");
    step(0, 0, 0, 0, 0, 0, 2, "R3 T1P to T2");
    step(0, 0, 0, 0, 0, 1, 0, "R4 end to idle");

    // F: next address in T1 has no effect
    push(16'h5000, 3, 0);
    step(1, 16'h5000, 3, 0, 0, 0, 1, "R2 idle to T1");
    step(1, 16'h5004, 4, 1, 0, 0, 2, "R6 na in T1");
    step(1, 16'h5004, 4, 0, 0, 0, 2, "R6 no pipelining from T1 na");
    push(16'h5004, 4, 0);
    step(1, 16'h5004, 4, 0, 0, 1, 1, "R4 plain issue");
    step(0, 0, 0, 0, 0, 0, 2, "R3 T1 to T2");
    step(0, 0, 0, 0, 0, 1, 0, "R4 end to idle");

    repeat (2) @(negedge clk);
    ck(exp_q.size(), 0, "R2 all issues seen");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule